// File: doc/BRIEF.md
# Punched-Card Read Transfer Sequencer

This block carries out one card-read command at a time. A processor-side port hands it an operation code, a begin address and an end address. For a read, the block takes 12-bit column images from the card reader one at a time. It turns each column into stored characters according to the selected mode and writes them into a memory addressed in 4-bit digits. When the card ends, it returns a one-cycle result. Three small control commands share the same sequencer: arm and wait for the reader, release the wait, and poll reader readiness.

Columns are translated outside the block. For the six-bit card code, a combinational translator supplies the stored character and a validity bit. For the eight-bit code, a combinational decoder supplies the character. The block chooses between these translator outputs and its own binary split. It also decides where each character goes, when storage stops and what fills a short card.

Top module: `card_read_seq`

## Requirements
- R1: Operation codes are two BCD digits on `cmd_op`. 8'h20 is six-bit-code read, 8'h21 is binary read, 8'h22 is eight-bit-code read, 8'h35 arms the input request, 8'h97 releases it and 8'h99 tests the reader. Any other code returns an exception result. `cmd_variant` has no effect on any output.
- R2: Each stored character is written at an even digit address. The first is written at the begin address, and each later one is 2 higher than the one before. No character is written at or above the end address.
- R3: At most 80 columns are stored per card. Columns beyond the 80th are still accepted (`col_ready` stays high) but write nothing.
- R4: Once the end address is reached, further columns are still accepted and produce no write. The command completes only at `card_end`.
- R5: If the card ends before 80 columns and the end address is not reached, the missing columns are filled with blanks. A blank is 8'h40 in the two character modes. In binary mode a blank is two 8'h00 characters, one for each slot. Filling stops under the same limits as R2 and R3.
- R6: In binary mode, column bits [11:6] are stored as {2'b00, bits} at address A. Bits [5:0] are stored the same way at A+2. The lower half is dropped if A+2 is not below the end address. The next column starts at A+4.
- R7: In six-bit-code mode, a column that the translator marks invalid is stored as 8'h3F. The result is then an exception, not complete.
- R8: In eight-bit-code mode, every column is stored as the decoder's output character and never causes an exception.
- R9: A read whose begin address is not a multiple of 4 writes nothing. It returns an exception result in the cycle after the command.
- R10: Arming (8'h35) returns a complete result only after the reader is ready and its start button is pressed together.
- R11: Releasing (8'h97) returns complete at once, whatever the reader is doing. Issued while an arm is waiting, it ends the wait with a single complete result.
- R12: Test (8'h99) returns complete when `rdr_ready` is high and not-ready when it is low.
- R13: Every result is a one-cycle `res_valid` pulse with exactly one of complete, not-ready and exception set. No write occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken while idle (release also while waiting) |
| cmd_op | input | 8 | Two-digit BCD operation code |
| cmd_variant | input | 16 | Option digits, ignored |
| cmd_bgn | input | AW | Begin digit address |
| cmd_fin | input | AW | End digit address (first address not written) |
| rdr_ready | input | 1 | Reader ready |
| rdr_start | input | 1 | Reader start button |
| col_valid | input | 1 | Column image present, taken when col_ready is high |
| col_data | input | 12 | Column hole image |
| card_end | input | 1 | End of card strobe, taken when col_ready is high |
| col_ready | output | 1 | Block can take a column or card end |
| bcl_char | input | 8 | Six-bit-code translator output for col_data |
| bcl_ok | input | 1 | Six-bit-code combination valid |
| ebc_char | input | 8 | Eight-bit-code decoder output for col_data |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory digit address |
| mem_wdata | output | 8 | Character written |
| busy | output | 1 | A command is in progress |
| res_valid | output | 1 | Result pulse |
| res_complete | output | 1 | Result: complete |
| res_not_ready | output | 1 | Result: reader not ready |
| res_exception | output | 1 | Result: exception |

## Verification
The sweep crosses the three read modes with card lengths of zero, short, exactly 80 and over 80 columns. It also crosses end addresses that allow no character, part of a binary column, exactly 80 characters and more than 80. It compares the whole memory image against an image built arithmetically. A design that miscounted the 80-column stop would overrun or underfill at the exact-80 and over-80 lengths. One that padded past the end address, or wrote a binary lower half into the end address, would leave stray bytes in the image. One that stopped accepting columns after the limit would hang before the card end. The control commands are checked for the exact cycles in which an arm must not answer, and for a release arriving during a wait.

// File: rtl/card_read_pkg.sv
// Shared types for the card read sequencer.
// Assumes operation codes arrive as two BCD digits.
package card_read_pkg;

    localparam logic [7:0] OP_RD_BCL  = 8'h20;
    localparam logic [7:0] OP_RD_BIN  = 8'h21;
    localparam logic [7:0] OP_RD_EBC  = 8'h22;
    localparam logic [7:0] OP_IRQ_ON  = 8'h35;
    localparam logic [7:0] OP_IRQ_OFF = 8'h97;
    localparam logic [7:0] OP_PROBE   = 8'h99;

    typedef enum logic [1:0] {MD_BCL, MD_BIN, MD_EBC} rd_mode_t;

    typedef enum logic [2:0] {
        KD_READ, KD_ARM, KD_RELEASE, KD_PROBE, KD_BAD
    } op_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_HALF, ST_PAD, ST_WAIT, ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {RS_COMPLETE, RS_NOTREADY, RS_EXCEPT} res_kind_t;

endpackage

// File: rtl/card_read_decode.sv
// Operation decoder: sorts a BCD operation code into a command kind and,
// for reads, a conversion mode. Pure combinational; unknown codes map to KD_BAD.
module card_read_decode
    import card_read_pkg::*;
(
    input  logic [7:0] op,
    output op_kind_t   kind,
    output rd_mode_t   mode
);

    // Classify the operation code.
    always_comb begin
        kind = KD_BAD;
        mode = MD_BCL;
        case (op)
            OP_RD_BCL:  begin kind = KD_READ; mode = MD_BCL; end
            OP_RD_BIN:  begin kind = KD_READ; mode = MD_BIN; end
            OP_RD_EBC:  begin kind = KD_READ; mode = MD_EBC; end
            OP_IRQ_ON:  kind = KD_ARM;
            OP_IRQ_OFF: kind = KD_RELEASE;
            OP_PROBE:   kind = KD_PROBE;
            default:    kind = KD_BAD;
        endcase
    end

endmodule

// File: rtl/card_read_charmap.sv
// Column-to-character mapper. Picks the external translator outputs or
// splits the column for binary mode. Assumes bcl_char/bcl_ok/ebc_char are
// combinational functions of the column currently on col.
module card_read_charmap
    import card_read_pkg::*;
#(
    parameter logic [7:0] INVALID_CHAR = 8'h3F
)(
    input  rd_mode_t    mode,
    input  logic [11:0] col,
    input  logic [7:0]  bcl_char,
    input  logic        bcl_ok,
    input  logic [7:0]  ebc_char,
    output logic [7:0]  first_char,
    output logic [7:0]  second_char,
    output logic        bad_code
);

    localparam int HALF_W = 6;

    // Select the stored character(s) for the active mode.
    always_comb begin
        second_char = '0;
        bad_code    = 1'b0;
        case (mode)
            MD_BIN: begin
                first_char  = {2'b00, col[2*HALF_W-1:HALF_W]};
                second_char = {2'b00, col[HALF_W-1:0]};
            end
            MD_EBC: first_char = ebc_char;
            default: begin
                first_char = bcl_ok ? bcl_char : INVALID_CHAR;
                bad_code   = !bcl_ok;
            end
        endcase
    end

endmodule

// File: rtl/card_read_cursor.sv
// Address and column cursor. Holds the current digit address, the end
// address and the count of columns consumed. "room" means the current
// address is below the end; "full" means no further column may be stored.
module card_read_cursor #(
    parameter int AW   = 16,
    parameter int NCOL = 80
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] bgn_addr,
    input  logic [AW-1:0] fin_addr,
    input  logic          step,
    input  logic          col_inc,
    output logic [AW-1:0] cur_addr,
    output logic          room,
    output logic          full
);

    localparam int CW = $clog2(NCOL + 1);
    localparam logic [AW-1:0] CHAR_STEP = AW'(2);

    logic [AW-1:0] fin_q;
    logic [CW-1:0] cnt_q;

    // Track the write address and the saturating column count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            fin_q    <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            cur_addr <= bgn_addr;
            fin_q    <= fin_addr;
            cnt_q    <= '0;
        end else begin
            if (step) cur_addr <= cur_addr + CHAR_STEP;
            if (col_inc && cnt_q != CW'(NCOL)) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign room = cur_addr < fin_q;
    assign full = !room || (cnt_q == CW'(NCOL));

endmodule

// File: rtl/card_read_seq.sv
// Card read sequencer top. Runs one command: reads store converted columns
// from the begin address upward, stop at the end address or the column
// limit, pad short cards with blanks and report one result pulse. Control
// commands arm, release and probe the reader. Assumes col_valid and
// card_end are never high together and are held only while col_ready.
module card_read_seq
    import card_read_pkg::*;
#(
    parameter int         AW           = 16,
    parameter int         NCOL         = 80,
    parameter logic [7:0] BLANK_CHAR   = 8'h40,
    parameter logic [7:0] INVALID_CHAR = 8'h3F
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_op,
    input  logic [15:0]   cmd_variant,
    input  logic [AW-1:0] cmd_bgn,
    input  logic [AW-1:0] cmd_fin,
    input  logic          rdr_ready,
    input  logic          rdr_start,
    input  logic          col_valid,
    input  logic [11:0]   col_data,
    input  logic          card_end,
    output logic          col_ready,
    input  logic [7:0]    bcl_char,
    input  logic          bcl_ok,
    input  logic [7:0]    ebc_char,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          busy,
    output logic          res_valid,
    output logic          res_complete,
    output logic          res_not_ready,
    output logic          res_exception
);

    localparam logic [7:0] BIN_BLANK = 8'h00;

    seq_state_t    state;
    seq_state_t    ret_q;
    rd_mode_t      mode_q;
    res_kind_t     rs_q;
    logic          exc_q;
    logic [7:0]    lo_q;

    op_kind_t      dec_kind;
    rd_mode_t      dec_mode;
    logic [7:0]    ch_first;
    logic [7:0]    ch_second;
    logic          ch_bad;
    logic [AW-1:0] cur_addr;
    logic          room;
    logic          full;
    logic          cur_load;
    logic          cur_step;
    logic          cur_colinc;
    logic          unused_variant;

    assign unused_variant = ^cmd_variant;

    card_read_decode u_decode (
        .op   (cmd_op),
        .kind (dec_kind),
        .mode (dec_mode)
    );

    card_read_charmap #(.INVALID_CHAR(INVALID_CHAR)) u_charmap (
        .mode        (mode_q),
        .col         (col_data),
        .bcl_char    (bcl_char),
        .bcl_ok      (bcl_ok),
        .ebc_char    (ebc_char),
        .first_char  (ch_first),
        .second_char (ch_second),
        .bad_code    (ch_bad)
    );

    card_read_cursor #(.AW(AW), .NCOL(NCOL)) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cur_load),
        .bgn_addr (cmd_bgn),
        .fin_addr (cmd_fin),
        .step     (cur_step),
        .col_inc  (cur_colinc),
        .cur_addr (cur_addr),
        .room     (room),
        .full     (full)
    );

    // Cursor controls: load on a new command, advance on every write.
    always_comb begin
        cur_load   = (state == ST_IDLE) && cmd_valid;
        cur_step   = ((state == ST_READ) && col_valid && !full)
                   || ((state == ST_HALF) && room)
                   || ((state == ST_PAD) && !full);
        cur_colinc = ((state == ST_READ) && col_valid)
                   || ((state == ST_PAD) && !full);
    end

    // Main sequencer: command dispatch, column storage, padding, results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ret_q     <= ST_READ;
            mode_q    <= MD_BCL;
            rs_q      <= RS_COMPLETE;
            exc_q     <= 1'b0;
            lo_q      <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        case (dec_kind)
                            KD_READ: begin
                                if (cmd_bgn[1:0] != 2'b00) begin
                                    rs_q  <= RS_EXCEPT;
                                    state <= ST_DONE;
                                end else begin
                                    mode_q <= dec_mode;
                                    exc_q  <= 1'b0;
                                    state  <= ST_READ;
                                end
                            end
                            KD_ARM:     state <= ST_WAIT;
                            KD_RELEASE: begin
                                rs_q  <= RS_COMPLETE;
                                state <= ST_DONE;
                            end
                            KD_PROBE: begin
                                rs_q  <= rdr_ready ? RS_COMPLETE : RS_NOTREADY;
                                state <= ST_DONE;
                            end
                            default: begin
                                rs_q  <= RS_EXCEPT;
                                state <= ST_DONE;
                            end
                        endcase
                    end
                end
                ST_READ: begin
                    if (col_valid) begin
                        if (!full) begin
                            mem_we    <= 1'b1;
                            mem_addr  <= cur_addr;
                            mem_wdata <= ch_first;
                            if (ch_bad) exc_q <= 1'b1;
                            if (mode_q == MD_BIN) begin
                                lo_q  <= ch_second;
                                ret_q <= ST_READ;
                                state <= ST_HALF;
                            end
                        end
                    end else if (card_end) begin
                        if (full) begin
                            rs_q  <= exc_q ? RS_EXCEPT : RS_COMPLETE;
                            state <= ST_DONE;
                        end else begin
                            state <= ST_PAD;
                        end
                    end
                end
                ST_HALF: begin
                    if (room) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= cur_addr;
                        mem_wdata <= lo_q;
                    end
                    state <= ret_q;
                end
                ST_PAD: begin
                    if (full) begin
                        rs_q  <= exc_q ? RS_EXCEPT : RS_COMPLETE;
                        state <= ST_DONE;
                    end else begin
                        mem_we   <= 1'b1;
                        mem_addr <= cur_addr;
                        if (mode_q == MD_BIN) begin
                            mem_wdata <= BIN_BLANK;
                            lo_q      <= BIN_BLANK;
                            ret_q     <= ST_PAD;
                            state     <= ST_HALF;
                        end else begin
                            mem_wdata <= BLANK_CHAR;
                        end
                    end
                end
                ST_WAIT: begin
                    if (cmd_valid && dec_kind == KD_RELEASE) begin
                        rs_q  <= RS_COMPLETE;
                        state <= ST_DONE;
                    end else if (rdr_ready && rdr_start) begin
                        rs_q  <= RS_COMPLETE;
                        state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign col_ready     = (state == ST_READ);
    assign busy          = (state != ST_IDLE);
    assign res_valid     = (state == ST_DONE);
    assign res_complete  = res_valid && (rs_q == RS_COMPLETE);
    assign res_not_ready = res_valid && (rs_q == RS_NOTREADY);
    assign res_exception = res_valid && (rs_q == RS_EXCEPT);

endmodule

// File: rtl/card_read_seq_chk.sv
// Property checker for card_read_seq, bound to every instance. It captures
// each accepted command on its own and checks writes and result pulses
// against it.
module card_read_seq_chk
    import card_read_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NCOL = 80
)(
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [7:0]    cmd_op,
    input logic [AW-1:0] cmd_bgn,
    input logic [AW-1:0] cmd_fin,
    input logic          busy,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_wdata,
    input logic          res_valid,
    input logic          res_complete,
    input logic          res_not_ready,
    input logic          res_exception
);

    localparam int WCW = $clog2(2 * NCOL + 2);

    logic [AW-1:0]  bgn_c, fin_c, last_addr;
    logic           bin_c, have_last;
    logic [WCW-1:0] wcnt;
    logic           take, is_read;

    assign take    = cmd_valid && !busy;
    assign is_read = (cmd_op == OP_RD_BCL) || (cmd_op == OP_RD_BIN) || (cmd_op == OP_RD_EBC);

    // Shadow the accepted command and count its writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bgn_c <= '0; fin_c <= '0; bin_c <= 1'b0;
            last_addr <= '0; have_last <= 1'b0; wcnt <= '0;
        end else if (take) begin
            bgn_c <= cmd_bgn; fin_c <= cmd_fin; bin_c <= (cmd_op == OP_RD_BIN);
            have_last <= 1'b0; wcnt <= '0;
        end else if (mem_we) begin
            last_addr <= mem_addr; have_last <= 1'b1; wcnt <= wcnt + 1'b1;
        end
    end

    a_r2_write_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= bgn_c) && (mem_addr < fin_c));
    a_r2_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !mem_addr[0]);
    a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && have_last) |-> (mem_addr == last_addr + AW'(2)));
    a_r3_write_limit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wcnt < WCW'(2 * NCOL)));
    a_r6_high_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && bin_c) |-> (mem_wdata[7:6] == 2'b00));
    a_r9_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_read && cmd_bgn[1:0] != 2'b00) |=> (res_valid && res_exception));
    a_r13_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot({res_complete, res_not_ready, res_exception}));
    a_r13_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !mem_we);

endmodule

bind card_read_seq card_read_seq_chk #(.AW(AW), .NCOL(NCOL)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_bgn       (cmd_bgn),
    .cmd_fin       (cmd_fin),
    .busy          (busy),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .res_valid     (res_valid),
    .res_complete  (res_complete),
    .res_not_ready (res_not_ready),
    .res_exception (res_exception)
);

// File: tb/card_read_seq_tb.sv
module card_read_seq_tb;

    localparam int AW   = 12;
    localparam int NCOL = 80;
    localparam int MSZ  = 1 << (AW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_op = '0;
    logic [15:0]   cmd_variant = '0;
    logic [AW-1:0] cmd_bgn = '0;
    logic [AW-1:0] cmd_fin = '0;
    logic          rdr_ready = 1'b0;
    logic          rdr_start = 1'b0;
    logic          col_valid = 1'b0;
    logic [11:0]   col_data = '0;
    logic          card_end = 1'b0;
    logic          col_ready;
    logic [7:0]    bcl_char;
    logic          bcl_ok;
    logic [7:0]    ebc_char;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          busy, res_valid, res_complete, res_not_ready, res_exception;

    int n_checks = 0;
    int n_fail   = 0;
    int wcount   = 0;
    int cyc      = 0;
    logic [7:0] got_m [0:MSZ-1];
    logic [7:0] exp_m [0:MSZ-1];

    always #4 clk = ~clk;

    // External translator models (supplied outside the block).
    function automatic logic        bcl_ok_of(input logic [11:0] c); return c[11:8] != 4'hF; endfunction
    function automatic logic [7:0]  bcl_of(input logic [11:0] c);    return {2'b00, c[5:0] ^ c[11:6]}; endfunction
    function automatic logic [7:0]  ebc_of(input logic [11:0] c);    return c[7:0] ^ {c[11:8], 4'h0}; endfunction
    function automatic logic [11:0] col_val(input int seed, input int i);
        if (i == 3) return 12'hF3C;
        return 12'((seed * 37 + i * 113 + i * i * 5) % 3840);
    endfunction

    assign bcl_ok   = bcl_ok_of(col_data);
    assign bcl_char = bcl_of(col_data);
    assign ebc_char = ebc_of(col_data);

    card_read_seq #(.AW(AW), .NCOL(NCOL)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_variant(cmd_variant), .cmd_bgn(cmd_bgn), .cmd_fin(cmd_fin),
        .rdr_ready(rdr_ready), .rdr_start(rdr_start), .col_valid(col_valid),
        .col_data(col_data), .card_end(card_end), .col_ready(col_ready),
        .bcl_char(bcl_char), .bcl_ok(bcl_ok), .ebc_char(ebc_char),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .res_valid(res_valid), .res_complete(res_complete),
        .res_not_ready(res_not_ready), .res_exception(res_exception)
    );

    // Memory model fed by the write port.
    always @(negedge clk) begin
        if (mem_we) begin
            got_m[mem_addr >> 1] = mem_wdata;
            wcount++;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_checks++; n_fail++;
            $display("FAIL R13 watchdog: actual no result, expected result before cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] op, input int bgn, input int fin, input logic [15:0] vd);
        cmd_op = op; cmd_bgn = AW'(bgn); cmd_fin = AW'(fin); cmd_variant = vd; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_result(output logic [2:0] flags);
        while (!res_valid) @(negedge clk);
        flags = {res_complete, res_not_ready, res_exception};
        @(negedge clk);
    endtask

    task automatic run_read(input logic [7:0] op, input int bgn, input int fin, input int ncols,
                            input int seed, input logic [15:0] vd, input string tag);
        int exp_w; logic exp_exc; int mism; int first_bad; logic [11:0] c; int a;
        logic [2:0] fl;
        for (int k = 0; k < MSZ; k++) begin got_m[k] = 8'hEE; exp_m[k] = 8'hEE; end
        wcount = 0; exp_w = 0; exp_exc = 1'b0;
        for (int i = 0; i < NCOL; i++) begin
            c = (i < ncols) ? col_val(seed, i) : 12'h000;
            if (op == 8'h21) begin
                a = bgn + 4 * i;
                if (a < fin) begin exp_m[a / 2] = {2'b00, c[11:6]}; exp_w++; end
                if (a + 2 < fin) begin exp_m[(a + 2) / 2] = {2'b00, c[5:0]}; exp_w++; end
            end else begin
                a = bgn + 2 * i;
                if (a < fin) begin
                    exp_w++;
                    if (i >= ncols) exp_m[a / 2] = 8'h40;
                    else if (op == 8'h22) exp_m[a / 2] = ebc_of(c);
                    else if (bcl_ok_of(c)) exp_m[a / 2] = bcl_of(c);
                    else begin exp_m[a / 2] = 8'h3F; exp_exc = 1'b1; end
                end
            end
        end
        send_cmd(op, bgn, fin, vd);
        for (int i = 0; i < ncols; i++) begin
            while (!col_ready) @(negedge clk);
            col_data = col_val(seed, i); col_valid = 1'b1;
            @(negedge clk);
            col_valid = 1'b0;
        end
        while (!col_ready) @(negedge clk);
        card_end = 1'b1;
        @(negedge clk);
        card_end = 1'b0;
        wait_result(fl);
        mism = 0; first_bad = -1;
        for (int k = 0; k < MSZ; k++)
            if (got_m[k] !== exp_m[k]) begin mism++; if (first_bad < 0) first_bad = k; end
        check(mism == 0, $sformatf("%s image op=%h n=%0d fin=%0d at digit %0d", tag, op, ncols, fin, first_bad * 2),
              (first_bad < 0) ? 0 : int'(got_m[first_bad]), (first_bad < 0) ? 0 : int'(exp_m[first_bad]));
        check(wcount == exp_w, $sformatf("%s R2 write count op=%h n=%0d fin=%0d", tag, op, ncols, fin), wcount, exp_w);
        check(fl == (exp_exc ? 3'b001 : 3'b100),
              $sformatf("%s R7 R8 R13 result op=%h n=%0d fin=%0d", tag, op, ncols, fin), fl, exp_exc ? 1 : 4);
    endtask

    task automatic run_ctl(input logic [7:0] op, input int bgn, input logic [2:0] exp_fl, input string tag);
        logic [2:0] fl;
        wcount = 0;
        send_cmd(op, bgn, bgn + 40, 16'h0);
        wait_result(fl);
        check(fl == exp_fl, {tag, " result flags"}, fl, exp_fl);
        check(wcount == 0, {tag, " no writes"}, wcount, 0);
    endtask

    initial begin
        int nlist [5];
        int flist [4];
        logic [7:0] ops [3];
        logic [2:0] fl;
        int seen;
        nlist = '{0, 4, 40, 80, 85};
        flist = '{0, 6, 160, 400};
        ops   = '{8'h20, 8'h21, 8'h22};

        repeat (3) @(negedge clk);
        // Reset state: idle, no result, no write, no column taken.
        check({busy, res_valid, mem_we, col_ready} == 4'b0000, "R13 reset state",
              {busy, res_valid, mem_we, col_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep modes, card lengths and end addresses (R2 R3 R4 R5 R6 R7 R8).
        for (int m = 0; m < 3; m++)
            for (int n = 0; n < 5; n++)
                for (int f = 0; f < 4; f++)
                    run_read(ops[m], 64, 64 + flist[f], nlist[n], m * 7 + n + f,
                             16'h0, (m == 1) ? "R3 R4 R5 R6" : "R3 R4 R5");

        // Begin at zero, odd remaining space in binary.
        run_read(8'h21, 0, 10, 6, 3, 16'h0, "R6 odd end");
        // R1: variant digits have no effect.
        run_read(8'h22, 128, 600, 30, 11, 16'h9999, "R1 variant");
        run_read(8'h20, 128, 600, 30, 11, 16'h5A5A, "R1 variant");

        // R9: misaligned begin addresses.
        run_ctl(8'h20, 66, 3'b001, "R9 misaligned bcl");
        run_ctl(8'h21, 65, 3'b001, "R9 misaligned bin");
        run_ctl(8'h22, 67, 3'b001, "R9 misaligned ebc");
        // R1: unknown operation codes.
        run_ctl(8'h45, 64, 3'b001, "R1 unknown op 45");
        run_ctl(8'h23, 64, 3'b001, "R1 unknown op 23");
        // R12: probe.
        rdr_ready = 1'b1;
        run_ctl(8'h99, 64, 3'b100, "R12 probe ready");
        rdr_ready = 1'b0;
        run_ctl(8'h99, 64, 3'b010, "R12 probe not ready");
        // R11: release while idle.
        run_ctl(8'h97, 64, 3'b100, "R11 release idle");

        // R10: arm waits for ready together with the start button.
        send_cmd(8'h35, 0, 0, 16'h0);
        seen = 0;
        for (int i = 0; i < 10; i++) begin if (res_valid) seen++; @(negedge clk); end
        rdr_ready = 1'b1;
        for (int i = 0; i < 6; i++) begin if (res_valid) seen++; @(negedge clk); end
        rdr_ready = 1'b0; rdr_start = 1'b1;
        for (int i = 0; i < 6; i++) begin if (res_valid) seen++; @(negedge clk); end
        check(seen == 0 && busy, "R10 no result before ready and start", seen, 0);
        rdr_ready = 1'b1;
        @(negedge clk);
        check(res_valid && res_complete, "R10 complete after ready and start",
              {res_valid, res_complete}, 3);
        rdr_ready = 1'b0; rdr_start = 1'b0;
        @(negedge clk);
        check(!busy, "R10 back to idle", busy, 0);

        // R11: release ends a waiting arm with one complete result.
        send_cmd(8'h35, 0, 0, 16'h0);
        repeat (4) @(negedge clk);
        send_cmd(8'h97, 0, 0, 16'h0);
        fl = {res_complete, res_not_ready, res_exception};
        check(res_valid && fl == 3'b100, "R11 release during wait", {res_valid, fl}, 4'b1100);
        @(negedge clk);
        seen = 0;
        for (int i = 0; i < 5; i++) begin if (res_valid || busy) seen++; @(negedge clk); end
        check(seen == 0, "R11 single result then idle", seen, 0);

        summary();
        $finish;
    end

endmodule